// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single input-capture channel that sits beside a free-running timer. Software programs a small control register to choose one of four input pins and the kind of transition that matters. When that transition is seen on the chosen pin, the block copies the current timer count into a capture register. It also sets a sticky event flag and, if enabled, raises an interrupt request.

Each of the four candidate pins passes through its own synchronizer. A single edge detector watches the selected synchronized pin. A plain register bus, with one address bit, gives read/write access to the control register and read access to the captured count. Reading the captured count, or writing a one to the flag bit, acknowledges the event. A new capture landing in the same cycle as an acknowledge keeps the flag set.

Top module: `tcap_channel`

## Requirements
- R1: After reset the control register reads 0, the capture register reads 0 and `irq_o` is low.
- R2: The control word (address 0) has these fields: bits 5:4 input select, bits 3:2 edge mode, bit 1 interrupt enable, bit 0 event flag. Bits 5:1 read back as written. A write can never set bit 0. The upper read bits are zero.
- R3: Input select 0 picks `cap_pin_i`, 1 picks `rx0_i`, 2 picks `rx1_i` and 3 picks `sync_pin_i`. Transitions on the unselected pins are ignored.
- R4: Edge mode 0 never captures. Mode 1 captures on low-to-high transitions, mode 2 on high-to-low transitions, and mode 3 on both.
- R5: A pin change set up before clock edge k is captured at edge k+2. The capture register (address 1) then holds the `timer_i` value presented at that edge. Between captures it holds its value. Every qualifying edge reloads it, even while the flag is still set.
- R6: Each capture sets the event flag. The flag stays set until it is acknowledged.
- R7: A control write with bit 0 = 1 clears the flag. A control write with bit 0 = 0 leaves the flag as it was.
- R8: A read strobe on address 1 clears the flag.
- R9: If a capture and an acknowledge fall in the same clock cycle, the flag stays set.
- R10: `irq_o` is high exactly when the interrupt enable bit and the event flag are both 1.
- R11: A control write that changes the input select or edge mode does not by itself cause a capture. Only a transition of the newly selected pin after the write counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | Dedicated capture pin (asynchronous) |
| rx0_i | input | 1 | Serial receive line 0 (asynchronous) |
| rx1_i | input | 1 | Serial receive line 1 (asynchronous) |
| sync_pin_i | input | 1 | Sync pin (asynchronous) |
| timer_i | input | 24 | Free-running timer count |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (side effect only on address 1) |
| addr_i | input | 1 | 0 = control word, 1 = captured count |
| wdata_i | input | 6 | Write data for the control word |
| rdata_o | output | 24 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus strobes and `timer_i` are stable and defined around each rising clock edge. They also assume that a read strobe is a single-cycle pulse. The pins may change at any time, because the synchronizers absorb that. The bench changes every input only on falling clock edges, so each input is settled well before the next rising edge. It holds every strobe for exactly one cycle. It keeps the timer fixed during each capture window, so the expected count is known without modelling the timer.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int unsigned CTRL_W = 6;

    typedef enum logic [1:0] {
        SRC_CAP  = 2'd0,
        SRC_RX0  = 2'd1,
        SRC_RX1  = 2'd2,
        SRC_SYNC = 2'd3
    } tcap_src_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } tcap_edge_e;

    typedef struct packed {
        tcap_src_e  src;
        tcap_edge_e mode;
        logic       ena;
        logic       flag;
    } tcap_ctrl_t;

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge
    import tcap_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sync_vec_i,
    input  tcap_src_e          sel_i,
    input  tcap_edge_e         mode_i,
    input  logic               cfg_wr_i,
    input  tcap_src_e          new_sel_i,
    output logic               cap_evt_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic cur, rise, fall;

    always_comb begin
        cur  = sync_vec_i[sel_i];
        rise = cur & ~st_q.prev;
        fall = ~cur & st_q.prev;
        unique case (mode_i)
            EDGE_RISE: cap_evt_o = rise;
            EDGE_FALL: cap_evt_o = fall;
            EDGE_BOTH: cap_evt_o = rise | fall;
            default:   cap_evt_o = 1'b0;
        endcase
        st_d = st_q;
        // a config write re-seeds history from the newly selected pin (R11)
        st_d.prev = cfg_wr_i ? sync_vec_i[new_sel_i] : cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_off_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EDGE_OFF) |-> !cap_evt_o);

    p_capture_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt_o && !$past(cfg_wr_i)) |-> (sync_vec_i[sel_i] != $past(sync_vec_i[sel_i])));
endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
    import tcap_pkg::*;
#(
    parameter int unsigned TIMER_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic               addr_i,
    input  logic [CTRL_W-1:0]  wdata_i,
    input  logic               cap_evt_i,
    input  logic [TIMER_W-1:0] timer_i,
    output tcap_ctrl_t         ctrl_o,
    output logic               cfg_wr_o,
    output logic [TIMER_W-1:0] rdata_o,
    output logic               irq_o
);
    localparam int unsigned PAD_W = TIMER_W - CTRL_W;

    typedef struct packed {
        tcap_ctrl_t         ctrl;
        logic [TIMER_W-1:0] data;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic ctrl_wr, data_rd, ack;

    always_comb begin
        ctrl_wr = wr_en_i && !addr_i;
        data_rd = rd_en_i && addr_i;
        ack     = (ctrl_wr && wdata_i[0]) || data_rd;
        st_d    = st_q;
        if (ctrl_wr) begin
            st_d.ctrl.src  = tcap_src_e'(wdata_i[5:4]);
            st_d.ctrl.mode = tcap_edge_e'(wdata_i[3:2]);
            st_d.ctrl.ena  = wdata_i[1];
        end
        if (cap_evt_i) begin
            st_d.data      = timer_i;
            st_d.ctrl.flag = 1'b1;
        end else if (ack) begin
            st_d.ctrl.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o   = st_q.ctrl;
    assign cfg_wr_o = ctrl_wr;
    assign rdata_o  = addr_i ? st_q.data : {{PAD_W{1'b0}}, st_q.ctrl};
    assign irq_o    = st_q.ctrl.ena & st_q.ctrl.flag;

    p_capture_loads_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_i |=> (st_q.data == $past(timer_i)));

    p_data_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt_i |=> $stable(st_q.data));

    p_capture_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_i |=> st_q.ctrl.flag);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.flag && !(wr_en_i && !addr_i && wdata_i[0]) && !(rd_en_i && addr_i))
            |=> st_q.ctrl.flag);

    p_write_one_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && wdata_i[0] && !cap_evt_i) |=> !st_q.ctrl.flag);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i && !cap_evt_i) |=> !st_q.ctrl.flag);
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int unsigned TIMER_W     = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_pin_i,
    input  logic               rx0_i,
    input  logic               rx1_i,
    input  logic               sync_pin_i,
    input  logic [TIMER_W-1:0] timer_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic               addr_i,
    input  logic [CTRL_W-1:0]  wdata_i,
    output logic [TIMER_W-1:0] rdata_o,
    output logic               irq_o
);
    localparam int unsigned NUM_SRC = 1 << $bits(tcap_src_e);

    logic [NUM_SRC-1:0] raw_vec, sync_vec;
    tcap_ctrl_t ctrl;
    logic cfg_wr, cap_evt;

    assign raw_vec = {sync_pin_i, rx1_i, rx0_i, cap_pin_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        tcap_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(raw_vec[g]),
            .sync_o (sync_vec[g])
        );
    end

    tcap_edge #(.NUM_SRC(NUM_SRC)) i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_vec_i(sync_vec),
        .sel_i     (ctrl.src),
        .mode_i    (ctrl.mode),
        .cfg_wr_i  (cfg_wr),
        .new_sel_i (tcap_src_e'(wdata_i[5:4])),
        .cap_evt_o (cap_evt)
    );

    tcap_regs #(.TIMER_W(TIMER_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .cap_evt_i(cap_evt),
        .timer_i  (timer_i),
        .ctrl_o   (ctrl),
        .cfg_wr_o (cfg_wr),
        .rdata_o  (rdata_o),
        .irq_o    (irq_o)
    );

    p_irq_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(cap_evt) || $past(wr_en_i && !addr_i)));

    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && ((wr_en_i && !addr_i && wdata_i[0]) || (rd_en_i && addr_i)))
            |=> ctrl.flag);
endmodule

// File: tb/test_tcap_channel.sv
module test_tcap_channel;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 24;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] pins = '0;
    logic [TW-1:0] timer = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [5:0] wdata = '0;
    logic [TW-1:0] rdata;
    logic irq;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcap_channel i_tcap_channel (
        .clk(clk), .rst_n(rst_n),
        .cap_pin_i(pins[0]), .rx0_i(pins[1]), .rx1_i(pins[2]), .sync_pin_i(pins[3]),
        .timer_i(timer), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [5:0] v);
        addr = 1'b0; wdata = v; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_data(output logic [TW-1:0] v);
        addr = 1'b1; rd_en = 1'b1;
        #1 v = rdata;
        tick(1);
        rd_en = 1'b0; addr = 1'b0;
    endtask

    task automatic peek_ctrl(output logic [5:0] v);
        addr = 1'b0;
        #1 v = rdata[5:0];
    endtask

    task automatic peek_data(output logic [TW-1:0] v);
        addr = 1'b1;
        #1 v = rdata;
        addr = 1'b0;
    endtask

    task automatic set_pin(input int idx, input logic val);
        pins[idx] = val;
        tick(SETTLE);
    endtask

    function automatic logic [5:0] cfg(input int src, input int mode, input bit ena);
        return {src[1:0], mode[1:0], ena, 1'b0};
    endfunction

    task automatic t_reset;
        logic [5:0] c; logic [TW-1:0] d;
        peek_ctrl(c);
        check(c == 6'd0, "R1 ctrl", c, 0);
        peek_data(d);
        check(d == 0, "R1 data", d, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_fields;
        logic [5:0] c;
        wr_ctrl(6'b111110);
        peek_ctrl(c);
        check(c == 6'b111110, "R2 readback", c, 6'b111110);
        check(rdata[TW-1:6] == 0, "R2 upper zero", rdata[TW-1:6], 0);
        wr_ctrl(6'b010101);
        peek_ctrl(c);
        check(c == 6'b010100, "R2 flag not settable", c, 6'b010100);
        wr_ctrl(6'b000000);
    endtask

    task automatic t_sources;
        logic [5:0] c;
        for (int s = 0; s < 4; s++) begin
            wr_ctrl(cfg(s, 1, 0) | 6'd1);
            for (int o = 0; o < 4; o++) begin
                if (o != s) set_pin(o, 1'b1);
            end
            peek_ctrl(c);
            check(c[0] == 1'b0, "R3 other pins ignored", c[0], 0);
            set_pin(s, 1'b1);
            peek_ctrl(c);
            check(c[0] == 1'b1, "R3 selected pin captures", c[0], 1);
            for (int o = 0; o < 4; o++) pins[o] = 1'b0;
            tick(SETTLE);
        end
        wr_ctrl(6'd1);
    endtask

    task automatic t_edges;
        logic [5:0] c;
        for (int m = 0; m < 4; m++) begin
            wr_ctrl(cfg(0, m, 0) | 6'd1);
            set_pin(0, 1'b1);
            peek_ctrl(c);
            check(c[0] == (m == 1 || m == 3), "R4 rising", c[0], (m == 1 || m == 3));
            wr_ctrl(cfg(0, m, 0) | 6'd1);
            set_pin(0, 1'b0);
            peek_ctrl(c);
            check(c[0] == (m == 2 || m == 3), "R4 falling", c[0], (m == 2 || m == 3));
        end
        wr_ctrl(6'd1);
    endtask

    task automatic t_latency;
        logic [5:0] c; logic [TW-1:0] d;
        wr_ctrl(cfg(0, 1, 0) | 6'd1);
        timer = 24'hA5A5A5;
        pins[0] = 1'b1;
        tick(2);
        peek_ctrl(c);
        check(c[0] == 1'b0, "R5 not before k+2", c[0], 0);
        tick(1);
        peek_ctrl(c);
        check(c[0] == 1'b1, "R5 at k+2", c[0], 1);
        timer = 24'h123456;
        tick(2);
        peek_data(d);
        check(d == 24'hA5A5A5, "R5 captured count held", d, 24'hA5A5A5);
        peek_ctrl(c);
        check(c[0] == 1'b1, "R6 flag sticky", c[0], 1);
        wr_ctrl(cfg(0, 1, 0));
        peek_ctrl(c);
        check(c[0] == 1'b1, "R7 write zero keeps flag", c[0], 1);
        wr_ctrl(cfg(0, 1, 0) | 6'd1);
        peek_ctrl(c);
        check(c[0] == 1'b0, "R7 write one clears", c[0], 0);
        pins[0] = 1'b0;
        tick(SETTLE);
    endtask

    task automatic t_recent_and_read;
        logic [5:0] c; logic [TW-1:0] d;
        wr_ctrl(cfg(0, 1, 0) | 6'd1);
        timer = 24'h000111;
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        timer = 24'h000222;
        set_pin(0, 1'b1);
        peek_data(d);
        check(d == 24'h000222, "R5 reload while flag set", d, 24'h000222);
        rd_data(d);
        check(d == 24'h000222, "R8 read value", d, 24'h000222);
        peek_ctrl(c);
        check(c[0] == 1'b0, "R8 read clears flag", c[0], 0);
        peek_ctrl(c);
        check(c[5:1] == cfg(0, 1, 0) >> 1, "R8 read keeps config", c[5:1], cfg(0, 1, 0) >> 1);
        set_pin(0, 1'b0);
    endtask

    task automatic t_set_wins;
        logic [5:0] c; logic [TW-1:0] d;
        wr_ctrl(cfg(0, 1, 0) | 6'd1);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        timer = 24'h0BEEF0;
        pins[0] = 1'b1;
        tick(2);
        addr = 1'b0; wdata = cfg(0, 1, 0) | 6'd1; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
        peek_ctrl(c);
        check(c[0] == 1'b1, "R9 set beats write clear", c[0], 1);
        set_pin(0, 1'b0);
        timer = 24'h0CAFE0;
        pins[0] = 1'b1;
        tick(2);
        addr = 1'b1; rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0; addr = 1'b0;
        peek_ctrl(c);
        check(c[0] == 1'b1, "R9 set beats read clear", c[0], 1);
        peek_data(d);
        check(d == 24'h0CAFE0, "R9 capture taken", d, 24'h0CAFE0);
        set_pin(0, 1'b0);
        wr_ctrl(6'd1);
    endtask

    task automatic t_irq;
        wr_ctrl(cfg(0, 1, 0) | 6'd1);
        set_pin(0, 1'b1);
        check(irq == 1'b0, "R10 flag without enable", irq, 0);
        wr_ctrl(cfg(0, 1, 1));
        check(irq == 1'b1, "R10 enable and flag", irq, 1);
        wr_ctrl(cfg(0, 1, 1) | 6'd1);
        check(irq == 1'b0, "R10 enable without flag", irq, 0);
        set_pin(0, 1'b0);
        wr_ctrl(6'd1);
    endtask

    task automatic t_rearm;
        logic [5:0] c;
        wr_ctrl(cfg(0, 1, 0) | 6'd1);
        set_pin(0, 1'b1);
        wr_ctrl(cfg(1, 2, 0) | 6'd1);
        tick(SETTLE);
        peek_ctrl(c);
        check(c[0] == 1'b0, "R11 no capture from switch", c[0], 0);
        set_pin(1, 1'b1);
        set_pin(1, 1'b0);
        peek_ctrl(c);
        check(c[0] == 1'b1, "R11 armed after switch", c[0], 1);
        pins = '0;
        tick(SETTLE);
        wr_ctrl(6'd1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_fields();
        t_sources();
        t_edges();
        t_latency();
        t_recent_and_read();
        t_set_wins();
        t_irq();
        t_rearm();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule